// File: doc/BRIEF.md
# Bundle Splitter and Class Steering Stage

This stage sits between instruction fetch and the execution back-end. Each cycle the fetch side may offer up to two fixed-size bundles on two lanes. Each bundle holds three instruction slots. The stage splits every offered bundle into its slots. Each valid slot goes into one of five per-class instruction queues, chosen by the class tag carried with the slot. The five classes are branch, memory, simple integer, complex integer and floating point. The queues decouple decode from execution. The back-end drains each queue through its own pop input and head outputs.

Progress is limited only by how many instructions each class queue can take in one cycle. That limit is its write-port count, reduced further by its free entries. The number of execution units plays no part. A bundle is taken whole or not at all. Lane 1 can advance only together with lane 0. When the second bundle does not fit, only the first is taken, and fetch offers the second again on a later cycle. The combinational `take_cnt` output tells fetch how many bundles were consumed: 0, 1 or 2.

The design has no state machine. Its only state is the pointer and occupancy registers of the five queues. The acceptance decision is purely combinational.

Top module: `bundle_steer`

## Requirements
- R1: After reset every class queue is empty (`q_head_vld` all zero), and with no bundle offered `take_cnt` is 0.
- R2: Class codes are 0 branch, 1 memory, 2 simple integer, 3 complex integer and 4 floating point. The instruction of a valid slot in a consumed bundle is written into the queue with that index.
- R3: A slot with its valid bit clear, or with a class code of 5, 6 or 7, is written nowhere and uses no write port.
- R4: The lane 0 bundle is consumed exactly when `bnd_valid[0]` is set and, for every class, its count of instructions is no larger than that queue's available ports.
- R5: The lane 1 bundle is consumed exactly when lane 0 is consumed, `bnd_valid[1]` is set, and for every class the summed need of both bundles fits the available ports. `take_cnt` equals the number of bundles consumed.
- R6: A bundle that is not consumed writes none of its slots.
- R7: The available ports of a queue are the smaller of `WR_PORTS` and its free entries. A full queue accepts nothing, and occupancy never exceeds `DEPTH`.
- R8: Within each queue, instructions leave in program order. Order runs by cycle, then lane 0 before lane 1, then slot 0, 1, 2.
- R9: A bundle offered on lane 1 while lane 0 is idle is not consumed.
- R10: A set `q_deq` bit removes that queue's head when the queue is non-empty. On an empty queue it has no effect.
- R11: An instruction written at a clock edge shows at the queue head after that same edge when the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_valid | input | 2 | Bundle offered on lane 0 / lane 1 |
| bnd_slot_vld | input | 6 | Slot valid, index lane*3+slot |
| bnd_slot_cls | input | 18 | 3-bit class code per slot, slot g at bits [3g+2:3g] |
| bnd_slot_insn | input | 6*INSN_W | Instruction word per slot, slot g at [g*INSN_W +: INSN_W] |
| take_cnt | output | 2 | Bundles consumed this cycle (0, 1, 2) |
| q_deq | input | 5 | Pop request per class queue |
| q_head_vld | output | 5 | Class queue non-empty |
| q_head_insn | output | 5*INSN_W | Head instruction of each class queue |

## Verification
`take_cnt` is a same-cycle result. The bench drives inputs on the falling edge and compares `take_cnt` one time unit later, before the rising edge that acts on it. Queue writes and pops take effect at the next rising edge. The head of each queue is therefore compared against the bench's behavioural queues on the following falling edge. Every stimulus cycle runs through the same task, so each result is sampled in the cycle it is due. Directed cycles also compare the consumed count against a literal value worked out from the port rules.

// File: rtl/bsteer_pkg.sv
package bsteer_pkg;
    localparam int NCLS  = 5;
    localparam int LANES = 2;
    localparam int SLOTS = 3;
    localparam int TOT   = LANES * SLOTS;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_BR  = 3'd0,
        CLS_MEM = 3'd1,
        CLS_ALU = 3'd2,
        CLS_CPX = 3'd3,
        CLS_FP  = 3'd4
    } cls_e;
endpackage

// File: rtl/bs_slot_tally.sv
module bs_slot_tally
    import bsteer_pkg::*;
(
    input  logic [SLOTS-1:0]       slot_vld,
    input  logic [SLOTS*CLS_W-1:0] slot_cls,
    output logic [NCLS-1:0][1:0]   need
);
    always_comb begin
        need = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int c = 0; c < NCLS; c++) begin
                if (slot_vld[s] && slot_cls[s*CLS_W +: CLS_W] == CLS_W'(c)) begin
                    need[c] = need[c] + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/bs_port_arbiter.sv
module bs_port_arbiter
    import bsteer_pkg::*;
#(
    parameter int WR_PORTS = 3,
    localparam int AV_W    = $clog2(WR_PORTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           offer,
    input  logic [NCLS-1:0][1:0]       need0,
    input  logic [NCLS-1:0][1:0]       need1,
    input  logic [NCLS-1:0][AV_W-1:0]  avail,
    output logic [LANES-1:0]           take,
    output logic [1:0]                 take_cnt
);
    logic fit0, fit01;

    always_comb begin
        fit0  = 1'b1;
        fit01 = 1'b1;
        for (int c = 0; c < NCLS; c++) begin
            if (int'(need0[c]) > int'(avail[c])) begin
                fit0 = 1'b0;
            end
            if (int'(need0[c]) + int'(need1[c]) > int'(avail[c])) begin
                fit01 = 1'b0;
            end
        end
    end

    always_comb begin
        take[0]  = offer[0] && fit0;
        take[1]  = take[0] && offer[1] && fit01;
        take_cnt = 2'(take[0]) + 2'(take[1]);
    end

    // R5
    second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cnt == 2'd2) |-> (offer == 2'b11));

    // R9
    idle_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !offer[0] |-> (take_cnt == 2'd0));
endmodule

// File: rtl/bs_class_fifo.sv
module bs_class_fifo #(
    parameter int INSN_W   = 41,
    parameter int DEPTH    = 8,
    parameter int WR_PORTS = 3,
    localparam int AV_W    = $clog2(WR_PORTS + 1),
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [AV_W-1:0]                  wr_cnt,
    input  logic [WR_PORTS-1:0][INSN_W-1:0]  wr_data,
    input  logic                             deq,
    output logic [AV_W-1:0]                  avail,
    output logic                             head_vld,
    output logic [INSN_W-1:0]                head_data
);
    logic [INSN_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count, free;
    logic              pop;

    always_comb begin
        free     = CNT_W'(DEPTH) - count;
        avail    = (free < CNT_W'(WR_PORTS)) ? AV_W'(free) : AV_W'(WR_PORTS);
        pop      = deq && (count != '0);
        head_vld = (count != '0);
        head_data = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(wr_cnt);
            rd_ptr <= rd_ptr + PTR_W'(pop);
            count  <= count + CNT_W'(wr_cnt) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WR_PORTS; i++) begin
            if (i < int'(wr_cnt)) begin
                mem[wr_ptr + PTR_W'(i)] <= wr_data[i];
            end
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7
    port_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= avail);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq && count == '0 && wr_cnt == '0) |=> (count == '0));

    // R11
    fill_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && wr_cnt != '0) |=> head_vld);
endmodule

// File: rtl/bundle_steer.sv
module bundle_steer
    import bsteer_pkg::*;
#(
    parameter int INSN_W   = 41,
    parameter int DEPTH    = 8,
    parameter int WR_PORTS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             bnd_valid,
    input  logic [5:0]             bnd_slot_vld,
    input  logic [17:0]            bnd_slot_cls,
    input  logic [6*INSN_W-1:0]    bnd_slot_insn,
    output logic [1:0]             take_cnt,
    input  logic [4:0]             q_deq,
    output logic [4:0]             q_head_vld,
    output logic [5*INSN_W-1:0]    q_head_insn
);
    localparam int AV_W = $clog2(WR_PORTS + 1);

    logic [LANES-1:0][NCLS-1:0][1:0] need;
    logic [NCLS-1:0][AV_W-1:0]       avail_all;
    logic [NCLS-1:0][AV_W-1:0]       wcnt_all;
    logic [LANES-1:0]                take;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bs_slot_tally u_tally (
            .slot_vld (bnd_slot_vld[l*SLOTS +: SLOTS]),
            .slot_cls (bnd_slot_cls[l*SLOTS*CLS_W +: SLOTS*CLS_W]),
            .need     (need[l])
        );
    end

    bs_port_arbiter #(.WR_PORTS(WR_PORTS)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .offer    (bnd_valid),
        .need0    (need[0]),
        .need1    (need[1]),
        .avail    (avail_all),
        .take     (take),
        .take_cnt (take_cnt)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic [WR_PORTS-1:0][INSN_W-1:0] wdat;
        logic [AV_W-1:0]                 wcnt;
        logic [AV_W-1:0]                 avl;
        logic [INSN_W-1:0]               hd;
        logic                            hv;

        // Compact the selected slots of this class in program order.
        always_comb begin
            int k;
            k    = 0;
            wdat = '0;
            for (int g = 0; g < TOT; g++) begin
                if (take[g / SLOTS] && bnd_slot_vld[g] &&
                    bnd_slot_cls[g*CLS_W +: CLS_W] == CLS_W'(c)) begin
                    if (k < WR_PORTS) begin
                        wdat[k] = bnd_slot_insn[g*INSN_W +: INSN_W];
                    end
                    k = k + 1;
                end
            end
            wcnt = AV_W'(k);
        end

        bs_class_fifo #(
            .INSN_W   (INSN_W),
            .DEPTH    (DEPTH),
            .WR_PORTS (WR_PORTS)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cnt    (wcnt),
            .wr_data   (wdat),
            .deq       (q_deq[c]),
            .avail     (avl),
            .head_vld  (hv),
            .head_data (hd)
        );

        assign avail_all[c] = avl;
        assign wcnt_all[c]  = wcnt;
        assign q_head_vld[c] = hv;
        assign q_head_insn[c*INSN_W +: INSN_W] = hd;
    end

    // R6
    reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cnt == 2'd0) |-> (wcnt_all == '0));
endmodule

// File: tb/bundle_steer_test.sv
module bundle_steer_test;
    localparam int CLK_PERIOD = 10;
    localparam int INSN_W   = 41;
    localparam int DEPTH    = 8;
    localparam int WR_PORTS = 3;
    localparam int NC       = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          bnd_valid = '0;
    logic [5:0]          bnd_slot_vld = '0;
    logic [17:0]         bnd_slot_cls = '0;
    logic [6*INSN_W-1:0] bnd_slot_insn = '0;
    logic [1:0]          take_cnt;
    logic [4:0]          q_deq = '0;
    logic [4:0]          q_head_vld;
    logic [5*INSN_W-1:0] q_head_insn;

    int errors = 0;
    int checks = 0;
    int seq = 1;
    logic [INSN_W-1:0] mq [NC][$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bundle_steer #(.INSN_W(INSN_W), .DEPTH(DEPTH), .WR_PORTS(WR_PORTS)) uut (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid),
        .bnd_slot_vld(bnd_slot_vld), .bnd_slot_cls(bnd_slot_cls),
        .bnd_slot_insn(bnd_slot_insn), .take_cnt(take_cnt),
        .q_deq(q_deq), .q_head_vld(q_head_vld), .q_head_insn(q_head_insn)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        bnd_valid = '0; bnd_slot_vld = '0; bnd_slot_cls = '0; bnd_slot_insn = '0; q_deq = '0;
    endtask

    task automatic put(input int lane, input int slot, input bit v, input int cls);
        int g;
        g = lane*3 + slot;
        bnd_slot_vld[g] = v;
        bnd_slot_cls[g*3 +: 3] = 3'(cls);
        bnd_slot_insn[g*INSN_W +: INSN_W] = INSN_W'(seq);
        seq++;
    endtask

    task automatic bundle(input int lane, input int c0, input int c1, input int c2);
        bnd_valid[lane] = 1'b1;
        put(lane, 0, c0 >= 0, (c0 >= 0) ? c0 : 0);
        put(lane, 1, c1 >= 0, (c1 >= 0) ? c1 : 0);
        put(lane, 2, c2 >= 0, (c2 >= 0) ? c2 : 0);
    endtask

    task automatic check_heads(input string req);
        for (int c = 0; c < NC; c++) begin
            chk(q_head_vld[c] == (mq[c].size() > 0), req, q_head_vld[c], mq[c].size() > 0);
            if (mq[c].size() > 0)
                chk(q_head_insn[c*INSN_W +: INSN_W] == mq[c][0], req,
                    q_head_insn[c*INSN_W +: INSN_W], mq[c][0]);
        end
    endtask

    // Inputs are set at a falling edge; exp < 0 means no literal expectation.
    task automatic cycle(input string req, input int exp);
        int av [NC];
        int n0 [NC];
        int n1 [NC];
        bit ok0, ok1;
        int mt;
        for (int c = 0; c < NC; c++) begin
            av[c] = DEPTH - mq[c].size();
            if (av[c] > WR_PORTS) av[c] = WR_PORTS;
            n0[c] = 0; n1[c] = 0;
        end
        for (int g = 0; g < 6; g++) begin
            int cl;
            cl = int'(bnd_slot_cls[g*3 +: 3]);
            if (bnd_slot_vld[g] && cl < NC) begin
                if (g < 3) n0[cl]++; else n1[cl]++;
            end
        end
        ok0 = bnd_valid[0];
        ok1 = bnd_valid[0] && bnd_valid[1];
        for (int c = 0; c < NC; c++) begin
            if (n0[c] > av[c]) ok0 = 1'b0;
            if (n0[c] + n1[c] > av[c]) ok1 = 1'b0;
        end
        ok1 = ok1 && ok0;
        mt = int'(ok0) + int'(ok1);
        #1;
        chk(int'(take_cnt) == mt, req, take_cnt, mt);
        if (exp >= 0) chk(int'(take_cnt) == exp, req, take_cnt, exp);
        @(posedge clk);
        for (int c = 0; c < NC; c++)
            if (q_deq[c] && mq[c].size() > 0) void'(mq[c].pop_front());
        for (int g = 0; g < 6; g++) begin
            int cl;
            cl = int'(bnd_slot_cls[g*3 +: 3]);
            if (((g < 3) ? ok0 : ok1) && bnd_slot_vld[g] && cl < NC)
                mq[cl].push_back(bnd_slot_insn[g*INSN_W +: INSN_W]);
        end
        @(negedge clk);
        check_heads(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty queues and no consumption after reset
        #1;
        chk(q_head_vld == 5'b0, "R1", q_head_vld, 0);
        chk(take_cnt == 2'd0, "R1", take_cnt, 0);
        @(negedge clk);

        // R2/R11: one bundle memory, simple int, complex int
        clear_in(); bundle(0, 1, 2, 3);
        cycle("R2 R11", 1);

        // R5/R8: two bundles, branch/mem/fp then alu/alu/cpx
        clear_in(); bundle(0, 0, 1, 4); bundle(1, 2, 2, 3);
        cycle("R5 R8", 2);

        // R5: four branches with three ports -> only lane 0 advances
        clear_in(); q_deq = 5'b11111; cycle("R10", -1);
        clear_in(); q_deq = 5'b11111; cycle("R10", -1);
        clear_in(); bundle(0, 0, 0, 1); bundle(1, 0, 0, 2);
        cycle("R5 four branches", 1);
        // fetch re-offers the held bundle on lane 0 (new words, same classes)
        clear_in(); q_deq = 5'b00001; bundle(0, 0, 0, 2);
        cycle("R5 retry", -1);

        // R3: invalid slots and codes 5..7 use no port
        clear_in(); q_deq = 5'b11111; cycle("R10", -1);
        clear_in(); q_deq = 5'b11111; cycle("R10", -1);
        clear_in(); q_deq = 5'b11111; cycle("R10", -1);
        clear_in();
        bundle(0, 0, 0, 0);
        bnd_valid[1] = 1'b1;
        put(1, 0, 1'b1, 5); put(1, 1, 1'b0, 0); put(1, 2, 1'b1, 7);
        cycle("R3", 2);

        // R9: lane 1 alone is not consumed
        clear_in(); bnd_valid[1] = 1'b1; put(1, 0, 1'b1, 4); put(1, 1, 1'b1, 4); put(1, 2, 1'b1, 4);
        cycle("R9", 0);

        // R7/R6: fill the memory queue
        clear_in(); q_deq = 5'b11111; cycle("R10", -1);
        clear_in(); q_deq = 5'b11111; cycle("R10", -1);
        clear_in(); bundle(0, 1, 1, 1); cycle("R7 fill", 1);
        clear_in(); bundle(0, 1, 1, 1); cycle("R7 fill", 1);
        clear_in(); bundle(0, 1, 1, 1); cycle("R7 two free", 0);
        clear_in(); bundle(0, 1, 1, 1); bundle(1, 0, -1, -1); cycle("R6 reject", 0);
        clear_in(); bundle(0, 1, 1, -1); cycle("R7 exact fit", 1);
        clear_in(); bundle(0, 1, -1, -1); cycle("R7 full", 0);
        clear_in(); bundle(0, 4, 4, 2); cycle("R4 other class", 1);

        // R10: drain memory queue and pop on empty
        for (int i = 0; i < 10; i++) begin
            clear_in(); q_deq = 5'b11111; cycle("R10 drain", -1);
        end
        chk(q_head_vld == 5'b0, "R10", q_head_vld, 0);

        // R4/R8: pseudo-random traffic compared every cycle
        lf = 32'h1ACE5;
        for (int n = 0; n < 400; n++) begin
            clear_in();
            for (int l = 0; l < 2; l++) begin
                for (int s = 0; s < 3; s++) begin
                    lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
                    put(l, s, lf[3:0] != 4'd0, int'(lf[6:4]) % 6);
                end
                bnd_valid[l] = lf[8] | lf[9];
            end
            lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
            q_deq = lf[4:0] & lf[9:5];
            cycle("R4 R8 random", -1);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule